// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer with Four Timeouts

This block is a watchdog that runs from a free-running internal RC clock. It does not use the system clock. Software must restart it with a kick pulse before the selected timeout runs out. If it does not, the block drives a reset pulse into the chip's reset network and sets a sticky flag. That flag lets software tell a watchdog reset apart from the other reset sources.

There are four timeouts, set by a two-bit select. They are multiples of a base period in the ratio 1:2:8:16. With the default base of 2048 RC cycles and an RC clock of about 15 kHz, they come out near 137 ms, 274 ms, 1.1 s and 2.2 s. The select value only takes effect when a kick arrives, so a change of select can never cause an immediate reset.

A suspend-enable bit can stop the watchdog while the device sits in the idle or stop power mode. When the device leaves that mode, counting starts again from zero. All pins are plain control and status signals: the block carries no data stream, so it has no valid/ready handshake.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is released, `wd_rst` and `wd_cause` are 0. The latched timeout code is 00 until the first kick.
- R2: The latched timeout code selects a limit of BASE_CYC times a multiplier: code 00 gives ×1, 01 gives ×2, 10 gives ×8 and 11 gives ×16. `wd_rst` rises exactly limit clock edges after the edge that sampled a kick, provided no further kick arrives.
- R3: A sampled kick clears the count to zero. Kicks spaced closer than the limit keep `wd_rst` low indefinitely.
- R4: A kick sampled on the edge at which the count would expire prevents the reset.
- R5: `tsel` is captured only on an edge that samples `kick`. A change of `tsel` without a kick leaves the running timeout unchanged.
- R6: While `wd_en` is 0, the count is held at zero and no reset is produced. After re-enabling, a full timeout elapses before expiry.
- R7: `pwr_mode` encodes 00 as fast, 01 as slow, 10 as idle and 11 as stop. When `lp_susp_en` is 1 and the mode is idle or stop, the count is held at zero and no reset occurs. On leaving such a mode, a full timeout elapses. With `lp_susp_en` at 0, the watchdog counts normally in idle and stop.
- R8: On expiry, `wd_rst` is high for exactly RST_CYC clock cycles. The count is held at zero during the pulse and restarts afterwards.
- R9: `wd_cause` is set on expiry and stays set until `cause_clr` is sampled. If an expiry and a clear fall on the same edge, the expiry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wd_en | input | 1 | Watchdog enable |
| kick | input | 1 | Restart pulse from software, one cycle |
| tsel | input | 2 | Timeout select, captured on kick |
| lp_susp_en | input | 1 | Suspend the watchdog in idle and stop modes |
| pwr_mode | input | 2 | Current power mode: 00 fast, 01 slow, 10 idle, 11 stop |
| cause_clr | input | 1 | Clear the sticky watchdog-reset flag |
| wd_rst | output | 1 | Watchdog reset pulse to the reset network |
| wd_cause | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The assertions assume that all inputs are synchronous to `clk_rc` and change only away from its rising edge. They also assume that `pwr_mode` holds one of the four defined codes. The bench drives every input on the falling edge and draws `pwr_mode` from the full two-bit range, so every code is legal. Random stimulus keeps kicks sparse enough that timeouts do expire. It also mixes in disable periods, suspend windows and clears that collide with expiry edges, so the corner cases in the requirements are reached.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  typedef enum logic [1:0] {
    PM_FAST = 2'b00,
    PM_SLOW = 2'b01,
    PM_IDLE = 2'b10,
    PM_STOP = 2'b11
  } pwr_mode_e;

  // Timeout multiplier for each select code (1:2:8:16)
  function automatic int unsigned tsel_mult(input int unsigned code);
    case (code)
      0:       return 1;
      1:       return 2;
      2:       return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_tsel_latch.sv
module wdt_tsel_latch #(
  parameter int unsigned BASE_CYC = 2048,
  parameter int unsigned CW       = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [1:0]    tsel_in,
  output logic [CW-1:0] limit_m1
);
  import wdt_guard_pkg::*;

  logic [1:0]    tsel_q;
  logic [CW-1:0] lim_tab [4];

  for (genvar i = 0; i < 4; i++) begin : g_lim
    localparam int unsigned LIM = BASE_CYC * tsel_mult(i);
    assign lim_tab[i] = CW'(LIM - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tsel_q <= 2'b00;
    else if (kick) tsel_q <= tsel_in;
  end

  assign limit_m1 = lim_tab[tsel_q];

  // R5
  tsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kick |=> $stable(tsel_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          hold,
  input  logic          kick,
  input  logic [CW-1:0] limit_m1,
  output logic          expire
);
  logic [CW-1:0] cnt;

  assign expire = active && !hold && !kick && (cnt == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!active || hold || kick)  cnt <= '0;
    else if (expire)                   cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit_m1);
  // R3
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt == '0);
  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0);
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic cause_clr,
  output logic wd_rst,
  output logic wd_cause
);
  localparam int unsigned PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (expire)        pcnt <= PW'(RST_CYC);
    else if (pcnt != '0)    pcnt <= pcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wd_cause <= 1'b0;
    else if (expire)     wd_cause <= 1'b1;
    else if (cause_clr)  wd_cause <= 1'b0;
  end

  assign wd_rst = (pcnt != '0);

  // R9
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wd_rst && wd_cause);
  // R9
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr && !expire |=> !wd_cause);
  // R8
  rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> $past(expire));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int unsigned BASE_CYC = 2048,
  parameter int unsigned RST_CYC  = 16
) (
  input  logic       clk_rc,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic       kick,
  input  logic [1:0] tsel,
  input  logic       lp_susp_en,
  input  logic [1:0] pwr_mode,
  input  logic       cause_clr,
  output logic       wd_rst,
  output logic       wd_cause
);
  import wdt_guard_pkg::*;

  localparam int unsigned CW = $clog2(BASE_CYC * 16);

  logic          low_pwr, active, expire;
  logic [CW-1:0] limit_m1;

  assign low_pwr = (pwr_mode == PM_IDLE) || (pwr_mode == PM_STOP);
  assign active  = wd_en && !(lp_susp_en && low_pwr);

  wdt_tsel_latch #(.BASE_CYC(BASE_CYC), .CW(CW)) u_sel (
    .clk(clk_rc), .rst_n(rst_n), .kick(kick), .tsel_in(tsel),
    .limit_m1(limit_m1)
  );

  wdt_counter #(.CW(CW)) u_cnt (
    .clk(clk_rc), .rst_n(rst_n), .active(active), .hold(wd_rst),
    .kick(kick), .limit_m1(limit_m1), .expire(expire)
  );

  wdt_rst_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk_rc), .rst_n(rst_n), .expire(expire), .cause_clr(cause_clr),
    .wd_rst(wd_rst), .wd_cause(wd_cause)
  );

  // R7
  suspend_no_expire_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (lp_susp_en && low_pwr) |-> !expire);
  // R6
  disabled_no_expire_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !wd_en |-> !expire);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam int unsigned BASE = 4;
  localparam int unsigned RLEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_en = 1'b1, kick = 1'b0, lp_susp_en = 1'b0, cause_clr = 1'b0;
  logic [1:0] tsel = 2'b00, pwr_mode = 2'b00;
  logic wd_rst, wd_cause;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  wdt_guard #(.BASE_CYC(BASE), .RST_CYC(RLEN)) uut (
    .clk_rc(clk), .rst_n(rst_n), .wd_en(wd_en), .kick(kick), .tsel(tsel),
    .lp_susp_en(lp_susp_en), .pwr_mode(pwr_mode), .cause_clr(cause_clr),
    .wd_rst(wd_rst), .wd_cause(wd_cause)
  );

  always #5 clk = ~clk;

  function automatic int lim(input logic [1:0] c);
    return BASE * ((c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 8 : 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // Reference model built from the requirements
  int m_cnt, m_p;
  logic [1:0] m_tsel;
  bit m_cause;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_p = 0; m_tsel = 2'b00; m_cause = 1'b0;
    end else begin
      bit act, hold, exp_e;
      act   = wd_en && !(lp_susp_en && pwr_mode[1]);
      hold  = (m_p != 0);
      exp_e = act && !hold && !kick && (m_cnt == lim(m_tsel) - 1);
      if (!act || hold || kick || exp_e) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (kick) m_tsel = tsel;
      if (exp_e) m_p = RLEN; else if (m_p != 0) m_p = m_p - 1;
      if (exp_e) m_cause = 1'b1; else if (cause_clr) m_cause = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(wd_rst == (m_p != 0), "R2/R8 model wd_rst", wd_rst, m_p != 0);
      chk(wd_cause == m_cause, "R9 model wd_cause", wd_cause, m_cause);
    end
  end

  task automatic kick_once(input logic [1:0] code);
    tsel = code; kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!wd_rst && n < 400);
  endtask

  task automatic wait_fall(output int w);
    w = 0;
    while (wd_rst && w < 100) begin @(negedge clk); w++; end
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!wd_rst, req, wd_rst, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, w;
    tsel = 2'b11;
    repeat (3) @(negedge clk);
    chk(!wd_rst && !wd_cause, "R1 reset outputs", {wd_rst, wd_cause}, 0);
    rst_n = 1'b1;
    chk(!wd_rst && !wd_cause, "R1 outputs after release", {wd_rst, wd_cause}, 0);
    // R1: code 00 in force before any kick although tsel=11
    wait_rise(n); chk(n == lim(2'b00), "R1 initial timeout code", n, lim(2'b00));
    // R8: pulse width and restart
    wait_fall(w); chk(w == RLEN, "R8 pulse width", w, RLEN);
    wait_rise(n); chk(n == lim(2'b00), "R8 restart after pulse", n, lim(2'b00));
    wait_fall(w);
    chk(wd_cause, "R9 cause sticky", wd_cause, 1);
    cause_clr = 1'b1; @(negedge clk); cause_clr = 1'b0;
    chk(!wd_cause, "R9 cause cleared", wd_cause, 0);

    // R2: every timeout code
    for (int c = 0; c < 4; c++) begin
      kick_once(2'(c));
      wait_rise(n); chk(n == lim(2'(c)), "R2 timeout length", n, lim(2'(c)));
      wait_fall(w);
    end

    // R3: regular kicks keep reset away
    for (int k = 0; k < 10; k++) begin
      kick_once(2'b01);
      quiet(lim(2'b01) - 2, "R3 kicked no reset");
    end

    // R4: kick on the expiry edge
    kick_once(2'b00);
    repeat (lim(2'b00) - 1) @(negedge clk);
    kick_once(2'b00);
    quiet(lim(2'b00) - 1, "R4 last-edge kick prevents reset");
    @(negedge clk); chk(wd_rst, "R4 expiry after last-edge kick", wd_rst, 1);
    wait_fall(w);

    // R5: select change without kick ignored
    kick_once(2'b00);
    tsel = 2'b11;
    wait_rise(n); chk(n == lim(2'b00), "R5 old timeout kept", n, lim(2'b00));
    wait_fall(w);
    kick_once(2'b11);
    wait_rise(n); chk(n == lim(2'b11), "R5 new timeout after kick", n, lim(2'b11));
    wait_fall(w);

    // R6: disable
    kick_once(2'b00);
    wd_en = 1'b0;
    quiet(100, "R6 disabled no reset");
    wd_en = 1'b1;
    wait_rise(n); chk(n == lim(2'b00), "R6 full timeout after enable", n, lim(2'b00));
    wait_fall(w);

    // R7: suspend in idle/stop, resume from zero
    kick_once(2'b01);
    repeat (3) @(negedge clk);
    lp_susp_en = 1'b1; pwr_mode = 2'b10;
    quiet(60, "R7 idle suspended");
    pwr_mode = 2'b11;
    quiet(60, "R7 stop suspended");
    pwr_mode = 2'b00;
    wait_rise(n); chk(n == lim(2'b01), "R7 full timeout after resume", n, lim(2'b01));
    wait_fall(w);
    lp_susp_en = 1'b0; pwr_mode = 2'b11;
    kick_once(2'b00);
    wait_rise(n); chk(n == lim(2'b00), "R7 counts in stop without suspend", n, lim(2'b00));
    wait_fall(w);
    pwr_mode = 2'b00;

    // R9: clear on the expiry edge loses
    cause_clr = 1'b1; @(negedge clk); cause_clr = 1'b0;
    kick_once(2'b00);
    repeat (lim(2'b00) - 1) @(negedge clk);
    cause_clr = 1'b1; @(negedge clk); cause_clr = 1'b0;
    chk(wd_rst && wd_cause, "R9 set wins over clear", {wd_rst, wd_cause}, 3);
    wait_fall(w);

    // Random phase, checked by the model each cycle
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      kick       = ($urandom % 14) == 0;
      tsel       = 2'($urandom % 4);
      cause_clr  = ($urandom % 25) == 0;
      if ($urandom % 40 == 0) wd_en = ($urandom % 8) != 0;
      if ($urandom % 50 == 0) lp_susp_en = $urandom % 2;
      if ($urandom % 40 == 0) pwr_mode = 2'($urandom % 4);
      @(negedge clk);
    end
    kick = 1'b0; cause_clr = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule